// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Non-Maskable Input

This block collects four active-low maskable interrupt lines and one active-low non-maskable line. It passes each line through a two-flop synchronizer and turns a falling edge into a latched pending flag. It then picks one request, presents it to the processor core as a request strobe together with a 16-bit vector address, and waits for the core to grant. After the grant, the block drives an acknowledge output for a fixed number of cycles while the core fetches the vector.

Two controls gate the maskable lines. A per-source enable register sets which lines may be taken, and a global disable bit blocks all of them at once. The non-maskable line bypasses both and has its own vector. Software sees the pending flags through a small register port. It clears a flag by writing a 1 to that bit, and a flag also clears when its interrupt is acknowledged. Taking a maskable interrupt sets the global disable bit. A return-from-interrupt pulse clears it again. While no request is outstanding, the vector output shows the restart address 0xFF80.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, the pending flags read 0, the enable register reads 0, the global disable bit reads 1, `core_req` and `iack` are 0, and `vec_addr` is 0xFF80.
- R2: A high-to-low transition on a line sets its pending flag at the third rising clock edge after the change. A line held low does not set the flag again after the flag is cleared.
- R3: Register address 0 reads the pending flags in bits 3:0, with line k in bit k. Writing a 1 to bit k at address 0 clears flag k, and writing a 0 leaves it unchanged.
- R4: A pending maskable flag k raises `core_req` only when enable bit k is 1 (address 1, bits 3:0) and the global disable bit is 0 (address 2, bit 0). Otherwise no request is made.
- R5: When several requests are eligible at once, the non-maskable source wins first, then line 0, and line 3 is served last.
- R6: A non-maskable falling edge is requested even when the global disable bit is 1 and the enable register is 0. Its vector is 0xFF84, and acknowledging it does not change the global disable bit.
- R7: The vector for maskable line k is 0xFF80 + 4*(k+2), which gives 0xFF88, 0xFF8C, 0xFF90 and 0xFF94.
- R8: `core_req` and `vec_addr` hold steady until `core_grant` is seen. After the grant edge, `iack` is high for exactly ACK_CYCLES (default 2) cycles with the vector held, and `core_req` is low.
- R9: Acknowledging maskable line k clears flag k and sets the global disable bit, at the grant edge.
- R10: A pulse on `reti` clears the global disable bit. The global disable bit can also be read and written at address 2, bit 0.
- R11: A request becomes eligible at the edge after its flag sets, so `core_req` rises one cycle after the flag. When an acknowledge ends, the next eligible request is raised one cycle after `iack` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_n | input | 4 | Maskable interrupt lines, active low |
| nmi_n | input | 1 | Non-maskable interrupt line, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 control |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| reti | input | 1 | Return-from-interrupt pulse |
| core_grant | input | 1 | Core accepts the pending request |
| core_req | output | 1 | Interrupt request to the core |
| iack | output | 1 | Acknowledge during the vector fetch |
| vec_addr | output | 16 | Vector address, or 0xFF80 when idle |

## Verification
The assertions check the handshake on every cycle. They confirm that an acknowledge only follows a granted request and always lasts exactly ACK_CYCLES, that the vector stays stable through the request and the acknowledge, that the vector reads 0xFF80 when idle, that a maskable request never starts while the global disable bit was set, and that taking one sets that bit. Only the bench scenarios can show the rest. These are the exact latency of the edge capture, the absence of a retrigger from a held-low line, the choice of winner when lines fall together (swept over every enable pattern), the non-maskable path with the global disable bit set, and the clearing of flags by write and by acknowledge.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_ACK  = 2'd2
  } irq_state_e;

  // Word offset of a source's vector slot from the restart base.
  // Slot 0 is restart, slot 1 the non-maskable source, slot k+2 line k.
  function automatic logic [31:0] vec_offset(input logic is_nmi, input int unsigned idx);
    if (is_nmi) return 32'd4;
    return (idx + 32'd2) * 32'd4;
  endfunction

endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_n,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic s1_q, s2_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q   <= 1'b1;
        s2_q   <= 1'b1;
        prev_q <= 1'b1;
      end else begin
        s1_q   <= line_n[i];
        s2_q   <= s1_q;
        prev_q <= s2_q;
      end
    end
    assign fall[i] = prev_q & ~s2_q;
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N  = 4,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]  cand,
  input  logic          nmi_pend,
  output logic          any,
  output logic [SW-1:0] src
);
  // Lowest index wins; the code N marks the non-maskable source.
  function automatic logic [SW-1:0] lowest_set(input logic [N-1:0] v);
    logic [SW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (v[i]) r = SW'(i);
    end
    return r;
  endfunction

  assign any = nmi_pend | (|cand);
  assign src = nmi_pend ? SW'(N) : lowest_set(cand);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int              N_EXT      = 4,
  parameter int              AW         = 16,
  parameter int              ACK_CYCLES = 2,
  parameter logic [AW-1:0]   VEC_BASE   = 16'hFF80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] irq_n,
  input  logic             nmi_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_EXT-1:0] reg_wdata,
  output logic [N_EXT-1:0] reg_rdata,
  input  logic             reti,
  input  logic             core_grant,
  output logic             core_req,
  output logic             iack,
  output logic [AW-1:0]    vec_addr
);
  import irq_pkg::*;

  localparam int SW = $clog2(N_EXT + 1);
  localparam int CW = $clog2(ACK_CYCLES + 1);
  localparam logic [SW-1:0] NMI_ID = SW'(N_EXT);
  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_MASK = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  // Edge capture for all lines, non-maskable line on top.
  logic [N_EXT:0] fall;
  irq_edge_sync #(.N(N_EXT + 1)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_n ({nmi_n, irq_n}),
    .fall   (fall)
  );

  irq_state_e     state_q;
  logic [CW-1:0]  cnt_q;
  logic [SW-1:0]  cur_src_q;
  logic [N_EXT-1:0] flag_q, imr_q;
  logic           intm_q, nmi_pend_q;

  // Named internal events.
  logic             take_ev, take_nmi, take_mask;
  logic [N_EXT-1:0] sw_clr, ack_clr, cand, cur_onehot;
  logic             pick_any;
  logic [SW-1:0]    pick_src;
  logic             unused_wbits;

  assign take_ev    = (state_q == ST_REQ) && core_grant;
  assign take_nmi   = take_ev && (cur_src_q == NMI_ID);
  assign take_mask  = take_ev && (cur_src_q != NMI_ID);
  assign cur_onehot = {{(N_EXT-1){1'b0}}, 1'b1} << cur_src_q;
  assign sw_clr     = (reg_we && reg_addr == A_FLAG) ? reg_wdata : '0;
  assign ack_clr    = take_mask ? cur_onehot : '0;
  assign cand       = flag_q & imr_q & {N_EXT{~intm_q}};
  assign unused_wbits = ^reg_wdata;

  irq_prio_pick #(.N(N_EXT), .SW(SW)) u_pick (
    .cand     (cand),
    .nmi_pend (nmi_pend_q),
    .any      (pick_any),
    .src      (pick_src)
  );

  // Flags, enables, global disable bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q     <= '0;
      imr_q      <= '0;
      intm_q     <= 1'b1;
      nmi_pend_q <= 1'b0;
    end else begin
      flag_q     <= (flag_q & ~(sw_clr | ack_clr)) | fall[N_EXT-1:0];
      nmi_pend_q <= (nmi_pend_q & ~take_nmi) | fall[N_EXT];
      if (reg_we && reg_addr == A_MASK) imr_q <= reg_wdata;
      if (take_mask)                         intm_q <= 1'b1;
      else if (reti)                         intm_q <= 1'b0;
      else if (reg_we && reg_addr == A_CTRL) intm_q <= reg_wdata[0];
    end
  end

  // Request / acknowledge sequencer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      cur_src_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pick_any) begin
          state_q   <= ST_REQ;
          cur_src_q <= pick_src;
        end
        ST_REQ: if (core_grant) begin
          state_q <= ST_ACK;
          cnt_q   <= CW'(ACK_CYCLES - 1);
        end
        ST_ACK: begin
          if (cnt_q == '0) state_q <= ST_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign core_req = (state_q == ST_REQ);
  assign iack     = (state_q == ST_ACK);
  assign vec_addr = (state_q == ST_IDLE) ? VEC_BASE
                  : VEC_BASE + AW'(vec_offset(cur_src_q == NMI_ID, 32'(cur_src_q)));

  always_comb begin
    unique case (reg_addr)
      A_FLAG:  reg_rdata = flag_q;
      A_MASK:  reg_rdata = imr_q;
      A_CTRL:  reg_rdata = {{(N_EXT-1){1'b0}}, intm_q};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int            AW         = 16,
  parameter int            ACK_CYCLES = 2,
  parameter logic [AW-1:0] VEC_BASE   = 16'hFF80
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_req,
  input logic          core_grant,
  input logic          iack,
  input logic [AW-1:0] vec_addr,
  input logic          intm_q
);
  localparam logic [AW-1:0] NMI_VEC = VEC_BASE + AW'(4);

  logic [7:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                run_q <= '0;
    else if (!iack)            run_q <= '0;
    else if (run_q != 8'hFF)   run_q <= run_q + 8'd1;
  end

  assert_idle_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_req && !iack) |-> vec_addr == VEC_BASE);

  assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(core_req) && vec_addr != NMI_VEC) |-> !$past(intm_q));

  assert_ack_follows_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iack) |-> $past(core_req && core_grant));

  assert_req_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (core_req && $past(core_req)) |-> $stable(vec_addr));

  assert_ack_vec_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && $past(core_req || iack)) |-> $stable(vec_addr));

  assert_ack_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iack) |-> run_q == 8'(ACK_CYCLES));

  assert_take_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(iack) && vec_addr != NMI_VEC) |-> intm_q);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .AW(AW), .ACK_CYCLES(ACK_CYCLES), .VEC_BASE(VEC_BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_req   (core_req),
  .core_grant (core_grant),
  .iack       (iack),
  .vec_addr   (vec_addr),
  .intm_q     (intm_q)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACKN = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_n = 4'hF;
  logic        nmi_n = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [3:0]  reg_wdata = 4'h0;
  logic [3:0]  reg_rdata;
  logic        reti = 1'b0;
  logic        core_grant = 1'b0;
  logic        core_req, iack;
  logic [15:0] vec_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.ACK_CYCLES(ACKN)) u_dut (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reti(reti), .core_grant(core_grant),
    .core_req(core_req), .iack(iack), .vec_addr(vec_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step(1);
    reg_we = 1'b0; reg_wdata = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [3:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  function automatic logic [15:0] exp_vec(input int k);
    return 16'hFF80 + 16'(4 * (k + 2));
  endfunction

  // Grant the current request and watch the acknowledge window.
  task automatic service(input string tag, input logic [15:0] v);
    core_grant = 1'b1;
    step(1);
    core_grant = 1'b0;
    for (int i = 0; i < ACKN; i++) begin
      check({tag, " iack high"}, {31'd0, iack}, 1);
      check({tag, " req low in ack"}, {31'd0, core_req}, 0);
      check({tag, " vec held"}, {16'd0, vec_addr}, {16'd0, v});
      if (i < ACKN - 1) step(1);
    end
    step(1);
    check({tag, " iack ends"}, {31'd0, iack}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] d;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1
    rd(2'd0, d); check("R1 flags", {28'd0, d}, 0);
    rd(2'd1, d); check("R1 imr", {28'd0, d}, 0);
    rd(2'd2, d); check("R1 intm", {28'd0, d}, 1);
    check("R1 req", {31'd0, core_req}, 0);
    check("R1 iack", {31'd0, iack}, 0);
    check("R1 vec", {16'd0, vec_addr}, 32'hFF80);

    // R2, R3, R4: masked line 2, edge latency, no retrigger, clear by write
    irq_n[2] = 1'b0;
    step(2);
    rd(2'd0, d); check("R2 flag not yet", {28'd0, d}, 0);
    step(1);
    rd(2'd0, d); check("R2 flag at third edge", {28'd0, d}, 4'b0100);
    step(3);
    check("R4 masked no req", {31'd0, core_req}, 0);
    wr(2'd0, 4'b0011);
    rd(2'd0, d); check("R3 write zero keeps", {28'd0, d}, 4'b0100);
    wr(2'd0, 4'b0100);
    rd(2'd0, d); check("R3 write one clears", {28'd0, d}, 0);
    step(5);
    rd(2'd0, d); check("R2 held low no retrigger", {28'd0, d}, 0);
    irq_n = 4'hF;
    step(4);

    // R4 with enable set but global disable still 1
    wr(2'd1, 4'hF);
    irq_n[1] = 1'b0;
    step(6);
    check("R4 intm blocks", {31'd0, core_req}, 0);
    irq_n = 4'hF;
    wr(2'd1, 4'h0);
    wr(2'd0, 4'hF);
    step(4);

    // R5, R7, R8, R9, R10, R11: all lines fall together, sweep every enable pattern
    for (int m = 0; m < 16; m++) begin
      int win;
      win = -1;
      for (int k = 3; k >= 0; k--) if (m[k]) win = k;
      wr(2'd1, 4'(m));
      wr(2'd2, 4'h0);
      rd(2'd2, d); check("R10 ctrl write", {28'd0, d}, 0);
      irq_n = 4'h0;
      step(3);
      rd(2'd0, d); check("R2 all flags", {28'd0, d}, 4'hF);
      check("R11 req one cycle after flag", {31'd0, core_req}, 0);
      step(1);
      check("R4/R5 req", {31'd0, core_req}, (win >= 0) ? 1 : 0);
      if (win >= 0) begin
        check("R5/R7 vector", {16'd0, vec_addr}, {16'd0, exp_vec(win)});
        step(2);
        check("R8 req held", {31'd0, core_req}, 1);
        check("R8 vec held", {16'd0, vec_addr}, {16'd0, exp_vec(win)});
        service("R8", exp_vec(win));
        rd(2'd0, d); check("R9 flag cleared", {28'd0, d}, 4'hF & ~(4'b1 << win));
        rd(2'd2, d); check("R9 intm set", {28'd0, d}, 1);
        check("R4 intm stops others", {31'd0, core_req}, 0);
        wr(2'd1, 4'h0);
        reti = 1'b1; step(1); reti = 1'b0;
        rd(2'd2, d); check("R10 reti clears", {28'd0, d}, 0);
      end
      wr(2'd0, 4'hF);
      wr(2'd2, 4'h1);
      irq_n = 4'hF;
      step(4);
    end

    // R6: non-maskable with global disable set and enables clear
    wr(2'd1, 4'h0);
    rd(2'd2, d); check("R6 precondition intm", {28'd0, d}, 1);
    nmi_n = 1'b0;
    step(4);
    check("R6 nmi req", {31'd0, core_req}, 1);
    check("R6 nmi vector", {16'd0, vec_addr}, 32'hFF84);
    service("R6", 16'hFF84);
    rd(2'd2, d); check("R6 intm unchanged", {28'd0, d}, 1);
    nmi_n = 1'b1;
    step(4);

    // R5, R11: nmi and line 3 together, nmi first then line 3 right after
    wr(2'd1, 4'hF);
    wr(2'd2, 4'h0);
    nmi_n = 1'b0; irq_n[3] = 1'b0;
    step(4);
    check("R5 nmi over line3", {16'd0, vec_addr}, 32'hFF84);
    service("R5", 16'hFF84);
    rd(2'd2, d); check("R6 intm stays 0", {28'd0, d}, 0);
    step(1);
    check("R11 next req", {31'd0, core_req}, 1);
    check("R5 line3 vector", {16'd0, vec_addr}, {16'd0, exp_vec(3)});
    service("R9", exp_vec(3));
    rd(2'd0, d); check("R9 line3 cleared", {28'd0, d}, 0);
    rd(2'd2, d); check("R9 intm after line3", {28'd0, d}, 1);
    check("R1 idle vector", {16'd0, vec_addr}, 32'hFF80);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule